// File: doc/BRIEF.md
# MSI-to-memory ring capture controller

This block accepts message-signalled interrupt writes and records each one as a 16-byte entry in a ring buffer in system memory. The entry goes out on a single-beat memory write request port. Software reads the entries from memory, acknowledges them by advancing a read offset, and is alerted by a level interrupt line while unread entries remain.

Software sets up the ring through a small register file. The registers are a control word, a 64-bit ring base split into two 32-bit halves, the read offset, and a write offset that software can only read. The ring size is chosen by a 2-bit code, from 32 KB to 256 KB.

The write offset counts freely and is never reduced to the ring size. Hardware applies the ring mask on its side when it forms memory addresses. Software must apply the same mask, `(size-1) & ~0xF`, to the value it reads back. When the ring is full, the block can either drop new messages and record an overflow, or overwrite the oldest entry. It can also raise the interrupt because the ring is full.

Top module: `msi_ring_capture`

## Requirements
- R1: After reset, every register reads zero, the interrupt output is low and no memory write is requested.
- R2: Register addresses are 0 for control, 3 for base bits 63:32, 4 for base bits 31:0, 5 for read offset and 6 for write offset. Writes to the read offset store the value with bits 3:0 cleared. Writes to address 6 have no effect. Unused addresses read zero.
- R3: A message accepted at a clock edge is followed in the next cycle by a one-cycle memory write request. Its data has bits 15:0 equal to message data bits 15:0 and all other 112 bits zero.
- R4: The write offset advances by 16 for each accepted message. Its readback is the raw counter, not reduced to the ring size.
- R5: The write address equals base plus (write offset AND mask), where mask = (2^(15+code) - 1) AND NOT 0xF. The code is control bits 9:8, so the address always lies inside the ring.
- R6: The interrupt is high when interrupt-enable (control bit 3) is set and the masked write offset differs from the masked read offset. Writing the read offset equal to the write offset clears it.
- R7: The ring is full when ((masked write offset + 16) AND mask) equals the masked read offset. When the ring is full and full-stop (control bit 4) is set, a message is dropped and the sticky overflow flag in control bit 15 is set. Writing control with bit 15 set clears the flag.
- R8: When the ring is full and full-stop is clear, the message is still written and the write offset still advances.
- R9: When global enable (bit 0) and full-interrupt enable (bit 1) are set and the ring is full, the interrupt is high even if interrupt-enable is clear.
- R10: While global enable is clear, messages cause no memory write and the write offset is held at zero. Clearing enable and interrupt-enable together drops the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msi_valid | input | 1 | An interrupt message arrives this cycle |
| msi_data | input | 32 | Message data word |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| mem_wr_valid | output | 1 | Memory write request, one cycle per entry |
| mem_wr_addr | output | 64 | Byte address of the entry |
| mem_wr_data | output | 128 | Entry contents, little-endian |
| irq | output | 1 | Interrupt level toward the processor |

## Verification
Each state change lands one clock edge after its stimulus. A memory write request, the advanced write offset, the overflow flag, and the interrupt reacting to a new entry or an acknowledge are all visible in the cycle after the edge that took the message or register write. Register readback is combinational in the same cycle as the address. The bench drives inputs just after each falling edge and updates a behavioural model at each rising edge. On every falling edge it compares all outputs with the model, so every result is checked exactly in the cycle it is due.

// File: rtl/msi_ring_capture.sv
module msi_ring_capture (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         msi_valid,
  input  logic [31:0]  msi_data,
  input  logic         reg_we,
  input  logic [2:0]   reg_addr,
  input  logic [31:0]  reg_wdata,
  output logic [31:0]  reg_rdata,
  output logic         mem_wr_valid,
  output logic [63:0]  mem_wr_addr,
  output logic [127:0] mem_wr_data,
  output logic         irq
);
  localparam logic [31:0] ENTRY_BYTES = 32'd16;
  localparam logic [31:0] MIN_RING    = 32'h8000;

  logic        en, full_ie, irq_ie, stop_ie, ovf;
  logic [1:0]  szc;
  logic [63:0] base;
  logic [31:0] rd_off, wr_off;

  logic [31:0] ring_bytes, mask, wr_m, rd_m;
  logic        full, pending, take, drop;

  assign ring_bytes = MIN_RING << szc;
  assign mask       = (ring_bytes - 32'd1) & ~32'hF;
  assign wr_m       = wr_off & mask;
  assign rd_m       = rd_off & mask;
  assign full       = ((wr_m + ENTRY_BYTES) & mask) == rd_m;
  assign pending    = wr_m != rd_m;
  assign take       = msi_valid && en && !(full && stop_ie);
  assign drop       = msi_valid && en && full && stop_ie;
  assign irq        = (irq_ie && pending) || (en && full_ie && full);

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {16'b0, ovf, 5'b0, szc, 3'b0, stop_ie, irq_ie, 1'b0, full_ie, en};
      3'd3:    reg_rdata = base[63:32];
      3'd4:    reg_rdata = base[31:0];
      3'd5:    reg_rdata = rd_off;
      3'd6:    reg_rdata = wr_off;
      default: reg_rdata = 32'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {en, full_ie, irq_ie, stop_ie, ovf} <= '0;
      szc          <= '0;
      base         <= '0;
      rd_off       <= '0;
      wr_off       <= '0;
      mem_wr_valid <= 1'b0;
      mem_wr_addr  <= '0;
      mem_wr_data  <= '0;
    end else begin
      if (reg_we) begin
        case (reg_addr)
          3'd0: begin
            en      <= reg_wdata[0];
            full_ie <= reg_wdata[1];
            irq_ie  <= reg_wdata[3];
            stop_ie <= reg_wdata[4];
            szc     <= reg_wdata[9:8];
          end
          3'd3:    base[63:32] <= reg_wdata;
          3'd4:    base[31:0]  <= reg_wdata;
          3'd5:    rd_off      <= {reg_wdata[31:4], 4'b0};
          default: ;
        endcase
      end
      if (drop) ovf <= 1'b1;
      else if (reg_we && reg_addr == 3'd0 && reg_wdata[15]) ovf <= 1'b0;

      if (!en)       wr_off <= '0;
      else if (take) wr_off <= wr_off + ENTRY_BYTES;

      mem_wr_valid <= take;
      if (take) begin
        mem_wr_addr <= base + {32'b0, wr_m};
        mem_wr_data <= {112'b0, msi_data[15:0]};
      end
    end
  end

  a_r3_write_follows_take: assert property (@(posedge clk) disable iff (!rst_n)
    (msi_valid && en && !(full && stop_ie)) |=> mem_wr_valid);
  a_r4_step_sixteen: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid |-> wr_off == $past(wr_off) + 32'd16);
  a_r5_addr_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid |-> (mem_wr_addr - $past(base)) < {32'b0, $past(ring_bytes)});
  a_r7_drop_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (msi_valid && en && full && stop_ie) |=> (!mem_wr_valid && ovf && $stable(wr_off)));
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (wr_off == 32'b0 && !mem_wr_valid));
  a_r2_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_off[3:0] == 4'b0) && (wr_off[3:0] == 4'b0));
endmodule

// File: tb/msi_ring_capture_bench.sv
module msi_ring_capture_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic msi_valid = 0, reg_we = 0;
  logic [31:0] msi_data = 0, reg_wdata = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_rdata;
  logic mem_wr_valid, irq;
  logic [63:0] mem_wr_addr;
  logic [127:0] mem_wr_data;

  int errors = 0, checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  msi_ring_capture u_msi_ring_capture (
    .clk(clk), .rst_n(rst_n), .msi_valid(msi_valid), .msi_data(msi_data),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .irq(irq));

  // behavioural reference state
  logic [31:0] m_ctrl, m_rd, m_wr;
  logic [63:0] m_base, m_addr;
  logic [127:0] m_data;
  logic m_valid;

  function automatic logic [31:0] m_mask(logic [31:0] c);
    return ((32'h8000 << c[9:8]) - 1) & ~32'hF;
  endfunction
  function automatic bit m_full();
    logic [31:0] k = m_mask(m_ctrl);
    return (((m_wr & k) + 16) & k) == (m_rd & k);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_rd = 0; m_wr = 0; m_base = 0; m_addr = 0; m_data = 0; m_valid = 0;
    end else begin
      logic [31:0] k, nc, nrd, nwr;
      logic [63:0] nb;
      bit fl, ok, dr;
      k = m_mask(m_ctrl); fl = m_full();
      ok = msi_valid && m_ctrl[0] && !(fl && m_ctrl[4]);
      dr = msi_valid && m_ctrl[0] && fl && m_ctrl[4];
      nc = m_ctrl; nrd = m_rd; nb = m_base; nwr = m_wr;
      if (reg_we) begin
        if (reg_addr == 0) nc = (reg_wdata & 32'h031B) | (m_ctrl & 32'h8000);
        if (reg_addr == 3) nb[63:32] = reg_wdata;
        if (reg_addr == 4) nb[31:0] = reg_wdata;
        if (reg_addr == 5) nrd = reg_wdata & ~32'hF;
      end
      if (dr) nc[15] = 1;
      else if (reg_we && reg_addr == 0 && reg_wdata[15]) nc[15] = 0;
      if (!m_ctrl[0]) nwr = 0; else if (ok) nwr = m_wr + 16;
      m_valid = ok;
      if (ok) begin
        m_addr = m_base + {32'b0, m_wr & k};
        m_data = {112'b0, msi_data[15:0]};
      end
      m_ctrl = nc; m_rd = nrd; m_base = nb; m_wr = nwr;
    end
  end

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] m_rdata();
    case (reg_addr)
      3'd0: return m_ctrl;
      3'd3: return m_base[63:32];
      3'd4: return m_base[31:0];
      3'd5: return m_rd;
      3'd6: return m_wr;
      default: return 0;
    endcase
  endfunction

  always @(negedge clk) if (rst_n) begin
    logic [31:0] k = m_mask(m_ctrl);
    chk("R6 irq", irq, (m_ctrl[3] && (m_wr & k) != (m_rd & k)) || (m_ctrl[0] && m_ctrl[1] && m_full()));
    chk("R3 write valid", mem_wr_valid, m_valid);
    if (m_valid) begin
      chk("R5 write addr", mem_wr_addr, m_addr);
      chk("R3 write data", mem_wr_data, m_data);
    end
    chk("R2 readback", reg_rdata, m_rdata());
  end

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); #1; reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); #1; reg_we = 0;
  endtask
  task automatic rd_chk(string req, logic [2:0] a, logic [31:0] exp);
    @(negedge clk); #1; reg_addr = a;
    @(negedge clk); chk(req, reg_rdata, exp);
  endtask
  task automatic send(int n, logic [31:0] seed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1; msi_valid = 1; msi_data = seed + i * 32'h9E37;
    end
    @(negedge clk); #1; msi_valid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1; rst_n = 1;
    @(negedge clk);
    chk("R1 irq", irq, 0);
    chk("R1 mem valid", mem_wr_valid, 0);
    rd_chk("R1 ctrl", 0, 0);
    rd_chk("R1 wr offset", 6, 0);
    wr(3, 32'h0000_0001);
    wr(4, 32'h8000_0000);
    rd_chk("R2 base hi", 3, 32'h1);
    rd_chk("R2 unused", 1, 0);
    wr(0, 32'h9);
    send(3, 32'h1234_ABCD);
    chk("R6 pending irq", irq, 1);
    rd_chk("R4 wr offset", 6, 32'h30);
    wr(5, 32'h3F);
    rd_chk("R2 rd aligned", 5, 32'h30);
    chk("R6 ack clears irq", irq, 0);
    wr(6, 32'h5550);
    rd_chk("R2 wr offset read-only", 6, 32'h30);
    wr(5, 32'h50);
    send(1, 32'hFFFF_0042);
    wr(0, 32'h19);
    send(2, 32'h7777);
    rd_chk("R7 ovf flag", 0, 32'h8019);
    rd_chk("R7 dropped, offset held", 6, 32'h40);
    wr(0, 32'h8019);
    rd_chk("R7 ovf cleared", 0, 32'h19);
    wr(0, 32'h3);
    chk("R9 full irq", irq, 1);
    wr(0, 32'h1);
    chk("R9 full irq off", irq, 0);
    wr(0, 32'h9);
    send(1, 32'hBEEF);
    rd_chk("R8 overwrite", 6, 32'h50);
    wr(0, 32'h0);
    send(4, 32'h4444);
    rd_chk("R10 offset zero", 6, 0);
    chk("R10 irq low", irq, 0);
    wr(5, 0);
    wr(0, 32'h9);
    send(2050, 32'h1000);
    rd_chk("R4 unwrapped", 6, 32'h8020);
    wr(0, 32'h119);
    send(40, 32'h2000);
    wr(0, 32'h0);
    wr(4, 32'h0001_0000);
    wr(0, 32'h30B);
    send(20, 32'h3000);
    wr(5, 32'h140);
    rd_chk("R5 size 3 offset", 6, 32'h140);
    chk("R6 caught up", irq, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule